// File: doc/BRIEF.md
# Smart Card Contact Power Sequencer

This block brings the contacts of a smart card up and down in a fixed order on command from a host. While idle it keeps the supply converter off and drives every card contact to ground. Only presence detection, which lives outside this block, stays active. A power-up request is the power command held high while the active-low chip select is low. The request starts the supply converter and captures the voltage-select bit. The block then waits for the supply-good flag. Only after that flag rises does it connect the card supply, then the I/O line, then the clock, then the reset line. Each of these steps lasts a parameterised number of clock cycles.

Deactivation runs the same steps in reverse: reset, clock, I/O, supply. Three events start it: a power-off command (power command low with chip select low), a card extraction event, or loss of supply-good. If the event arrives partway through activation, deactivation begins at the step that matches the highest contact already connected. Once the card is active, the levels on the I/O, clock and reset contacts follow the values the host drives. The block never raises the card reset by itself, so it never starts an answer-to-reset. While chip select is high, the card I/O driver is in high impedance.

The states are STANDBY (`ST_IDLE`), RAMP (`ST_RAMP`), the activation steps `ST_UP_VCC`, `ST_UP_IO`, `ST_UP_CLK` and `ST_UP_RST`, ACTIVE (`ST_ACTIVE`), and the deactivation steps `ST_DN_RST`, `ST_DN_CLK`, `ST_DN_IO` and `ST_DN_VCC`. The transitions are:
- IDLE to RAMP on a power-up request.
- RAMP to UP_VCC when supply-good is high.
- RAMP to DN_VCC on a power-off command or an extraction.
- Each UP step to the next UP step (UP_RST to ACTIVE) once its step time ends.
- UP_VCC, UP_IO, UP_CLK and UP_RST to DN_VCC, DN_IO, DN_CLK and DN_RST respectively on an abort.
- ACTIVE to DN_RST on an abort.
- Each DN step to the next DN step (DN_VCC to IDLE) once its step time ends.

An abort is a power-off command, an extraction, or supply-good low.

Top module: `card_pwr_seq`

## Requirements
- R1: After reset, and in standby, conv_en, vcc_en, io_en, clk_en, rst_en, io_oe, card_io, card_clk, card_rst and busy are all 0. A pulse on extract_evt in standby changes none of them.
- R2: A power-up request (pwr_cmd=1 with host_cs=0) in standby sets conv_en and busy in the next cycle. conv_vsel takes the value of volt_sel at the request and holds it until the next request.
- R3: While the converter runs and vcc_en is 0 (ramp), every contact enable and every card level stays 0. The ramp ends in the cycle after vcc_good is seen high.
- R4: Activation turns on vcc_en, then io_en, then clk_en, then rst_en. Each step lasts exactly STEP_CYC cycles. busy falls in the first ACTIVE cycle, when all four enables are 1.
- R5: In ACTIVE, card_io, card_clk and card_rst equal host_io, host_clk and host_rst. io_oe is 1 while host_cs is 0.
- R6: While host_cs is 1, io_oe is 0 and pwr_cmd has no effect. A card in ACTIVE keeps all enables on when pwr_cmd is lowered with host_cs high.
- R7: A power-off command in ACTIVE turns off rst_en, then clk_en, then io_en, then vcc_en together with conv_en. Each step lasts STEP_CYC cycles, and the block then returns to standby.
- R8: A one-cycle extract_evt pulse in ACTIVE starts the same deactivation sequence as R7.
- R9: vcc_good going low in ACTIVE starts the same deactivation sequence as R7.
- R10: An abort during ramp or activation enters deactivation at the step that matches the highest contact already on. No enable ever rises during deactivation.
- R11: A power-up request held during deactivation has no effect until standby is reached. It is then accepted after one standby cycle.
- R12: card_rst is never 1 outside ACTIVE, whatever host_rst is. The block never produces a reset edge of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_cs | input | 1 | Chip select from host, active low (1 = deselected) |
| pwr_cmd | input | 1 | Power command level from host |
| vcc_good | input | 1 | Card supply has reached the programmed voltage |
| volt_sel | input | 1 | Requested supply voltage: 0 = low, 1 = high |
| extract_evt | input | 1 | One-cycle pulse: card removed |
| host_io | input | 1 | I/O level the host wants on the card |
| host_clk | input | 1 | Clock level the host wants on the card |
| host_rst | input | 1 | Reset level the host wants on the card |
| conv_en | output | 1 | Supply converter enable |
| conv_vsel | output | 1 | Voltage select captured at the power-up request |
| vcc_en | output | 1 | Card supply switch enable |
| io_en | output | 1 | Card I/O contact enable |
| clk_en | output | 1 | Card clock contact enable |
| rst_en | output | 1 | Card reset contact enable |
| io_oe | output | 1 | Card I/O driver enable (0 = high impedance) |
| card_io | output | 1 | Level driven on card I/O |
| card_clk | output | 1 | Level driven on card clock |
| card_rst | output | 1 | Level driven on card reset |
| busy | output | 1 | Ramp, activation or deactivation in progress |

## Verification
The hardest cases to reach are aborts that land in the middle of activation. Each one must enter deactivation at exactly the matching step. The bench reaches them by counting cycles from the rise of vcc_good and injecting an extraction pulse inside the clock-enable step. A second path holds vcc_good low so that the converter stays in ramp, then issues a power-off command there. The bench also keeps a power-up request asserted through an entire deactivation caused by a supply drop. This shows that the request is only taken up after the single standby cycle.

// File: rtl/card_pwr_pkg.sv
package card_pwr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RAMP,
        ST_UP_VCC,
        ST_UP_IO,
        ST_UP_CLK,
        ST_UP_RST,
        ST_ACTIVE,
        ST_DN_RST,
        ST_DN_CLK,
        ST_DN_IO,
        ST_DN_VCC
    } seq_state_t;

    typedef struct packed {
        logic vcc;
        logic io;
        logic clk;
        logic rst;
    } contact_en_t;

endpackage

// File: rtl/cps_step_timer.sv
module cps_step_timer #(
    parameter int STEP_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic done
);
    localparam int CW = (STEP_CYC < 2) ? 1 : $clog2(STEP_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(STEP_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == LAST);

    // R4: step counter stays inside the step window
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/cps_cmd_decode.sv
module cps_cmd_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic host_cs,
    input  logic pwr_cmd,
    input  logic vcc_good,
    input  logic volt_sel,
    input  logic extract_evt,
    input  logic take_vsel,
    output logic up_req,
    output logic off_req,
    output logic stop_req,
    output logic conv_vsel
);
    logic vsel_q;

    always_comb begin
        up_req   = pwr_cmd && !host_cs;
        off_req  = !pwr_cmd && !host_cs;
        stop_req = off_req || extract_evt || !vcc_good;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vsel_q <= 1'b0;
        end else if (take_vsel) begin
            vsel_q <= volt_sel;
        end
    end

    assign conv_vsel = vsel_q;

    // R6: a deselected host can issue neither request
    a_r6_cs_gates_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        host_cs |-> !(up_req || off_req));

    // R2: captured select is stable unless a capture happened
    a_r2_vsel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(take_vsel) |-> $stable(conv_vsel));

endmodule

// File: rtl/cps_contact_drv.sv
module cps_contact_drv
    import card_pwr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  contact_en_t en,
    input  logic        live,
    input  logic        host_cs,
    input  logic        host_io,
    input  logic        host_clk,
    input  logic        host_rst,
    output logic        io_oe,
    output logic        card_io,
    output logic        card_clk,
    output logic        card_rst
);
    always_comb begin
        io_oe    = en.io && !host_cs;
        card_io  = live && en.io  && host_io;
        card_clk = live && en.clk && host_clk;
        card_rst = live && en.rst && host_rst;
    end

    // R6: deselected host means high impedance on card I/O
    a_r6_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        host_cs |-> !io_oe);

    // R3: no level reaches the card without its supply
    a_r3_no_glitch: assert property (@(posedge clk) disable iff (!rst_n)
        !en.vcc |-> !(card_io || card_clk || card_rst || io_oe));

endmodule

// File: rtl/card_pwr_seq.sv
module card_pwr_seq
    import card_pwr_pkg::*;
#(
    parameter int STEP_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_cs,
    input  logic pwr_cmd,
    input  logic vcc_good,
    input  logic volt_sel,
    input  logic extract_evt,
    input  logic host_io,
    input  logic host_clk,
    input  logic host_rst,
    output logic conv_en,
    output logic conv_vsel,
    output logic vcc_en,
    output logic io_en,
    output logic clk_en,
    output logic rst_en,
    output logic io_oe,
    output logic card_io,
    output logic card_clk,
    output logic card_rst,
    output logic busy
);
    seq_state_t  state_q, state_d;
    contact_en_t en;
    logic        up_req, off_req, stop_req;
    logic        step_done;
    logic        live;
    logic        take_vsel;

    cps_cmd_decode u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_cs     (host_cs),
        .pwr_cmd     (pwr_cmd),
        .vcc_good    (vcc_good),
        .volt_sel    (volt_sel),
        .extract_evt (extract_evt),
        .take_vsel   (take_vsel),
        .up_req      (up_req),
        .off_req     (off_req),
        .stop_req    (stop_req),
        .conv_vsel   (conv_vsel)
    );

    cps_step_timer #(.STEP_CYC(STEP_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q != state_d),
        .done  (step_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (up_req) state_d = ST_RAMP;
            ST_RAMP: begin
                if (off_req || extract_evt) state_d = ST_DN_VCC;
                else if (vcc_good)          state_d = ST_UP_VCC;
            end
            ST_UP_VCC: begin
                if (stop_req)       state_d = ST_DN_VCC;
                else if (step_done) state_d = ST_UP_IO;
            end
            ST_UP_IO: begin
                if (stop_req)       state_d = ST_DN_IO;
                else if (step_done) state_d = ST_UP_CLK;
            end
            ST_UP_CLK: begin
                if (stop_req)       state_d = ST_DN_CLK;
                else if (step_done) state_d = ST_UP_RST;
            end
            ST_UP_RST: begin
                if (stop_req)       state_d = ST_DN_RST;
                else if (step_done) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: if (stop_req)  state_d = ST_DN_RST;
            ST_DN_RST: if (step_done) state_d = ST_DN_CLK;
            ST_DN_CLK: if (step_done) state_d = ST_DN_IO;
            ST_DN_IO:  if (step_done) state_d = ST_DN_VCC;
            ST_DN_VCC: if (step_done) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // output decode
    always_comb begin
        en        = '0;
        conv_en   = 1'b0;
        busy      = 1'b1;
        live      = 1'b0;
        take_vsel = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy      = 1'b0;
                take_vsel = up_req;
            end
            ST_RAMP:   conv_en = 1'b1;
            ST_UP_VCC: begin conv_en = 1'b1; en = 4'b1000; end
            ST_UP_IO:  begin conv_en = 1'b1; en = 4'b1100; end
            ST_UP_CLK: begin conv_en = 1'b1; en = 4'b1110; end
            ST_UP_RST: begin conv_en = 1'b1; en = 4'b1111; end
            ST_ACTIVE: begin
                conv_en = 1'b1;
                en      = 4'b1111;
                busy    = 1'b0;
                live    = 1'b1;
            end
            ST_DN_RST: begin conv_en = 1'b1; en = 4'b1110; end
            ST_DN_CLK: begin conv_en = 1'b1; en = 4'b1100; end
            ST_DN_IO:  begin conv_en = 1'b1; en = 4'b1000; end
            ST_DN_VCC: ;
            default:   busy = 1'b0;
        endcase
    end

    assign vcc_en = en.vcc;
    assign io_en  = en.io;
    assign clk_en = en.clk;
    assign rst_en = en.rst;

    cps_contact_drv u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .live     (live),
        .host_cs  (host_cs),
        .host_io  (host_io),
        .host_clk (host_clk),
        .host_rst (host_rst),
        .io_oe    (io_oe),
        .card_io  (card_io),
        .card_clk (card_clk),
        .card_rst (card_rst)
    );

    // R1: standby keeps the converter off
    a_r1_standby_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !(conv_en || vcc_en));

    // R3: contacts only with the converter running
    a_r3_vcc_needs_conv: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_en |-> conv_en);

    // R4: activation order
    a_r4_io_after_vcc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_en) |-> $past(vcc_en));
    a_r4_clk_after_io: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en) |-> $past(io_en));
    a_r4_rst_after_clk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_en) |-> $past(clk_en));

    // R7: deactivation order
    a_r7_clk_off_after_rst: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_en) |-> !$past(rst_en));
    a_r7_io_off_after_clk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(io_en) |-> !$past(clk_en));
    a_r7_vcc_off_after_io: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vcc_en) |-> !$past(io_en));

    // R6: supply held while the card is live and nothing asks to stop
    a_r6_hold_supply: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && pwr_cmd && vcc_good && !extract_evt) |=> vcc_en);

    // R11: converter only starts out of standby
    a_r11_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_en) |-> !$past(busy));

    // R12: card reset only with its contact on and the sequence finished
    a_r12_no_self_reset: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |-> (rst_en && !busy));

endmodule

// File: tb/tb_card_pwr_seq.sv
module tb_card_pwr_seq;

    localparam int STEP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_cs = 1'b1, pwr_cmd = 1'b0, vcc_good = 1'b0, volt_sel = 1'b0;
    logic extract_evt = 1'b0, host_io = 1'b0, host_clk = 1'b0, host_rst = 1'b0;
    logic conv_en, conv_vsel, vcc_en, io_en, clk_en, rst_en;
    logic io_oe, card_io, card_clk, card_rst, busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    card_pwr_seq #(.STEP_CYC(STEP)) dut (
        .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .pwr_cmd(pwr_cmd),
        .vcc_good(vcc_good), .volt_sel(volt_sel), .extract_evt(extract_evt),
        .host_io(host_io), .host_clk(host_clk), .host_rst(host_rst),
        .conv_en(conv_en), .conv_vsel(conv_vsel), .vcc_en(vcc_en),
        .io_en(io_en), .clk_en(clk_en), .rst_en(rst_en), .io_oe(io_oe),
        .card_io(card_io), .card_clk(card_clk), .card_rst(card_rst),
        .busy(busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // n cycles with enables {vcc,io,clk,rst}=e, converter c, busy b; card_rst must stay 0
    task automatic stage(input string req, input logic [3:0] e, input logic c,
                         input logic b, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            extract_evt = 1'b0;
            chk(req, {vcc_en, io_en, clk_en, rst_en}, e);
            chk(req, conv_en, c);
            chk(req, busy, b);
            if (b) chk("R12", card_rst, 1'b0);
        end
    endtask

    task automatic deact_tail(input string req);
        stage(req, 4'b1110, 1'b1, 1'b1, STEP);
        stage(req, 4'b1100, 1'b1, 1'b1, STEP);
        stage(req, 4'b1000, 1'b1, 1'b1, STEP);
        stage(req, 4'b0000, 1'b0, 1'b1, STEP);
    endtask

    task automatic t_reset;
        chk("R1", {conv_en, vcc_en, io_en, clk_en, rst_en, io_oe, card_io,
                   card_clk, card_rst, busy}, 10'h0);
        @(negedge clk);
        extract_evt = 1'b1;
        stage("R1", 4'b0000, 1'b0, 1'b0, 3);
    endtask

    task automatic t_power_up(input logic vs);
        @(negedge clk);
        host_cs = 1'b0; pwr_cmd = 1'b1; volt_sel = vs; vcc_good = 1'b0;
        host_rst = 1'b1; host_io = 1'b1; host_clk = 1'b1;
        stage("R2", 4'b0000, 1'b1, 1'b1, 1);
        volt_sel = ~vs;
        stage("R3", 4'b0000, 1'b1, 1'b1, 3);
        chk("R3", {card_io, card_clk, card_rst, io_oe}, 4'h0);
        vcc_good = 1'b1;
        stage("R4", 4'b1000, 1'b1, 1'b1, STEP);
        stage("R4", 4'b1100, 1'b1, 1'b1, STEP);
        stage("R4", 4'b1110, 1'b1, 1'b1, STEP);
        stage("R4", 4'b1111, 1'b1, 1'b1, STEP);
        stage("R4", 4'b1111, 1'b1, 1'b0, 1);
        chk("R2", conv_vsel, vs);
    endtask

    task automatic t_levels;
        host_io = 1'b0; host_clk = 1'b1; host_rst = 1'b0;
        @(negedge clk);
        chk("R5", {card_io, card_clk, card_rst, io_oe}, 4'b0101);
        host_io = 1'b1; host_clk = 1'b0; host_rst = 1'b1;
        @(negedge clk);
        chk("R5", {card_io, card_clk, card_rst, io_oe}, 4'b1011);
    endtask

    task automatic t_cs_high;
        host_cs = 1'b1;
        @(negedge clk);
        chk("R6", io_oe, 1'b0);
        pwr_cmd = 1'b0;
        stage("R6", 4'b1111, 1'b1, 1'b0, 4);
        chk("R6", io_oe, 1'b0);
    endtask

    task automatic t_cmd_off;
        host_cs = 1'b0; pwr_cmd = 1'b0;
        deact_tail("R7");
        stage("R7", 4'b0000, 1'b0, 1'b0, 2);
    endtask

    task automatic t_extract;
        t_power_up(1'b0);
        pwr_cmd = 1'b0; host_cs = 1'b1; extract_evt = 1'b1;
        deact_tail("R8");
        stage("R8", 4'b0000, 1'b0, 1'b0, 2);
    endtask

    task automatic t_supply_drop;
        t_power_up(1'b1);
        vcc_good = 1'b0;
        deact_tail("R9");
        // request still held: one standby cycle, then ramp again
        stage("R11", 4'b0000, 1'b0, 1'b0, 1);
        stage("R11", 4'b0000, 1'b1, 1'b1, 2);
        // power-off while ramping goes straight to supply-off step
        pwr_cmd = 1'b0;
        stage("R10", 4'b0000, 1'b0, 1'b1, STEP);
        stage("R10", 4'b0000, 1'b0, 1'b0, 1);
    endtask

    task automatic t_abort;
        @(negedge clk);
        host_cs = 1'b0; pwr_cmd = 1'b1; vcc_good = 1'b1;
        stage("R10", 4'b0000, 1'b1, 1'b1, 1);
        stage("R10", 4'b1000, 1'b1, 1'b1, STEP);
        stage("R10", 4'b1100, 1'b1, 1'b1, STEP);
        stage("R10", 4'b1110, 1'b1, 1'b1, 1);
        extract_evt = 1'b1; pwr_cmd = 1'b0;
        stage("R10", 4'b1100, 1'b1, 1'b1, STEP);
        stage("R10", 4'b1000, 1'b1, 1'b1, STEP);
        stage("R10", 4'b0000, 1'b0, 1'b1, STEP);
        stage("R10", 4'b0000, 1'b0, 1'b0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_power_up(1'b1);
        t_levels;
        t_cs_high;
        t_cmd_off;
        t_extract;
        t_supply_drop;
        t_abort;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule